// File: doc/BRIEF.md
# Serial-Link Receiver Lock Sequencer

This block is the control state machine of a serial-link receiver. It takes the
receiver from power-down to locking on a local reference clock, and then to
locking on the incoming serial data. After that it watches for loss of lock.
The phase-locked loops, the clock multiplexer, the word aligner and the data
path are outside the block. The block only tells them what to do, through five
plain control levels. No pin carries a data stream, so there is no handshake
and no back-pressure.

Leaving power-down starts a reference-lock wait of fixed length, counted in
reference-clock ticks. The wait is longer when the spread-spectrum strap is
set, because a second loop must also settle. The block then hunts for a
transition word. A word found in normal mode declares lock at once. In
spread-spectrum mode a further settle count runs before lock is declared.

While locked, each transition word restarts a timeout. If the timeout runs out,
or the line stops toggling, the block goes back to the reference clock and
forces the data low. It then resumes the hunt. Every change of clock source
comes with a one-cycle stretch request. All timing runs on one system clock,
with the reference clock seen as a tick enable.

Top module: `link_lock_ctrl`

## Requirements
- R1: With `pd_n` low, `out_en` is 0 one cycle later and all counts are held at zero. The first cycle after `pd_n` is seen high drives `out_en`=1, `lock_n`=1, `data_low`=1 and `clk_sel_rec`=0.
- R2: In normal mode (`ss_mode`=0) the reference-lock wait ends on the REF_WAIT_CYC-th `ref_tick` after power-up. Only cycles with `ref_tick` high count. A `word_found` during the wait is ignored.
- R3: In spread-spectrum mode (`ss_mode`=1) the reference-lock wait lasts SS_REF_WAIT_CYC ticks. A `word_found` before the last of those ticks is ignored.
- R4: During the hunt, in normal mode, a `word_found` with `line_active` high gives `lock_n`=0, `data_low`=0 and `clk_sel_rec`=1 in the next cycle.
- R5: During the hunt, in spread-spectrum mode, a `word_found` starts a settle count. Lock (as in R4) is declared on the SS_SETTLE_CYC-th `ref_tick` after the word, and not before.
- R6: While locked, if WORD_TIMEOUT_CYC ticks pass without a `word_found`, the block returns to `lock_n`=1, `data_low`=1 and `clk_sel_rec`=0 in the cycle after the last tick. The hunt then continues, and a later word relocks.
- R7: While locked, each `word_found` restarts the timeout count from zero.
- R8: While hunting, settling or locked, `line_active`=0 gives `lock_n`=1, `data_low`=1 and `clk_sel_rec`=0 in the next cycle. Words are ignored until `line_active` returns. The hunt then restarts.
- R9: `clk_stretch` is high for exactly the one cycle in which `clk_sel_rec` takes a new value, in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_n | input | 1 | Power-down pin, low means powered down |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| word_found | input | 1 | Transition word seen by the aligner |
| line_active | input | 1 | Serial input is toggling |
| ss_mode | input | 1 | Spread-spectrum strap, static during operation |
| lock_n | output | 1 | High while not locked |
| out_en | output | 1 | 1 drives the outputs, 0 puts them in high impedance |
| data_low | output | 1 | Forces the parallel data outputs low |
| clk_sel_rec | output | 1 | 1 selects the recovered clock, 0 the reference clock |
| clk_stretch | output | 1 | One-cycle request to stretch the output clock at a source change |

## Verification
The bench places a transition word one tick before the end of the reference wait and again right at its end, in both modes. A design with an off-by-one count, or one that counts system cycles instead of ticks, would lock early or late. It sends a word just before the timeout expires and then lets the timeout run out. A design that does not restart the count would drop lock too soon, and one that never times out would stay locked. It drops line activity and pulses a word while the line is idle, to catch a design that relocks on a dead line or ignores inactivity. It checks the stretch pulse on both the lock and unlock edges, to catch a request that is missing or lasts two cycles.

// File: rtl/link_lock_pkg.sv
package link_lock_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_REFLK  = 3'd1,
    ST_HUNT   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_LOCKED = 3'd4,
    ST_NOLINE = 3'd5
  } lk_state_e;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/lock_timer.sv
module lock_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (clr)           cnt <= '0;
    else if (run && tick)   cnt <= cnt + 1'b1;
  end

  assign done = run && tick && (cnt == limit - 1'b1);

  // R6 R7: the running count never passes its terminal value
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import link_lock_pkg::*;
#(
  parameter int CNT_W           = 8,
  parameter int REF_WAIT_CYC    = 16,
  parameter int SS_REF_WAIT_CYC = 32,
  parameter int SS_SETTLE_CYC   = 8,
  parameter int WORD_TIMEOUT_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             word_found,
  input  logic             line_active,
  input  logic             ss_mode,
  input  logic             tmr_done,
  output lk_state_e        state,
  output logic             tmr_run,
  output logic             tmr_clr,
  output logic [CNT_W-1:0] tmr_limit
);
  localparam logic [CNT_W-1:0] LIM_REF   = CNT_W'(REF_WAIT_CYC);
  localparam logic [CNT_W-1:0] LIM_REFSS = CNT_W'(SS_REF_WAIT_CYC);
  localparam logic [CNT_W-1:0] LIM_SET   = CNT_W'(SS_SETTLE_CYC);
  localparam logic [CNT_W-1:0] LIM_TO    = CNT_W'(WORD_TIMEOUT_CYC);

  lk_state_e nx;

  always_comb begin
    nx = state;
    case (state)
      ST_OFF:    if (pd_n) nx = ST_REFLK;
      ST_REFLK:  if (tmr_done) nx = ST_HUNT;
      ST_HUNT:   if (!line_active) nx = ST_NOLINE;
                 else if (word_found) nx = ss_mode ? ST_SETTLE : ST_LOCKED;
      ST_SETTLE: if (!line_active) nx = ST_NOLINE;
                 else if (tmr_done) nx = ST_LOCKED;
      ST_LOCKED: if (!line_active) nx = ST_NOLINE;
                 else if (!word_found && tmr_done) nx = ST_HUNT;
      ST_NOLINE: if (line_active) nx = ST_HUNT;
      default:   nx = ST_OFF;
    endcase
    if (!pd_n) nx = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nx;
  end

  always_comb begin
    tmr_run = (state == ST_REFLK) || (state == ST_SETTLE) || (state == ST_LOCKED);
    tmr_clr = (nx != state) || (state == ST_OFF) ||
              ((state == ST_LOCKED) && word_found);
    case (state)
      ST_REFLK:  tmr_limit = ss_mode ? LIM_REFSS : LIM_REF;
      ST_SETTLE: tmr_limit = LIM_SET;
      ST_LOCKED: tmr_limit = LIM_TO;
      default:   tmr_limit = CNT_W'(1);
    endcase
  end

  // R2 R3: the hunt is entered from the reference wait only when its count ends
  assert_ref_wait_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_HUNT) && ($past(state) == ST_REFLK)) |-> $past(tmr_done));

  // R4 R5: lock is entered only from a live word in the hunt or a finished settle
  assert_lock_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_LOCKED) && ($past(state) != ST_LOCKED)) |->
      (($past(state) == ST_HUNT) && $past(word_found && line_active && !ss_mode)) ||
      (($past(state) == ST_SETTLE) && $past(tmr_done)));
endmodule

// File: rtl/lock_outputs.sv
module lock_outputs
  import link_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lk_state_e state,
  output logic      lock_n,
  output logic      out_en,
  output logic      data_low,
  output logic      clk_sel_rec,
  output logic      clk_stretch
);
  logic sel_q;

  always_comb begin
    out_en      = (state != ST_OFF);
    lock_n      = (state != ST_LOCKED);
    data_low    = (state != ST_LOCKED);
    clk_sel_rec = (state == ST_LOCKED);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= clk_sel_rec;
  end

  assign clk_stretch = sel_q ^ clk_sel_rec;
endmodule

// File: rtl/link_lock_ctrl.sv
module link_lock_ctrl
  import link_lock_pkg::*;
#(
  parameter int REF_WAIT_CYC     = 16928,
  parameter int SS_REF_WAIT_CYC  = 33600,
  parameter int SS_SETTLE_CYC    = 288,
  parameter int WORD_TIMEOUT_CYC = 4194304
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  input  logic ref_tick,
  input  logic word_found,
  input  logic line_active,
  input  logic ss_mode,
  output logic lock_n,
  output logic out_en,
  output logic data_low,
  output logic clk_sel_rec,
  output logic clk_stretch
);
  localparam int unsigned MAX_CNT = max4(REF_WAIT_CYC, SS_REF_WAIT_CYC,
                                         SS_SETTLE_CYC, WORD_TIMEOUT_CYC);
  localparam int CNT_W = $clog2(MAX_CNT + 1);

  lk_state_e        state;
  logic             tmr_run, tmr_clr, tmr_done;
  logic [CNT_W-1:0] tmr_limit;

  lock_fsm #(
    .CNT_W(CNT_W), .REF_WAIT_CYC(REF_WAIT_CYC), .SS_REF_WAIT_CYC(SS_REF_WAIT_CYC),
    .SS_SETTLE_CYC(SS_SETTLE_CYC), .WORD_TIMEOUT_CYC(WORD_TIMEOUT_CYC)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .word_found(word_found),
    .line_active(line_active), .ss_mode(ss_mode), .tmr_done(tmr_done),
    .state(state), .tmr_run(tmr_run), .tmr_clr(tmr_clr), .tmr_limit(tmr_limit)
  );

  lock_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .clr(tmr_clr),
    .tick(ref_tick), .limit(tmr_limit), .done(tmr_done)
  );

  lock_outputs out_i (
    .clk(clk), .rst_n(rst_n), .state(state), .lock_n(lock_n), .out_en(out_en),
    .data_low(data_low), .clk_sel_rec(clk_sel_rec), .clk_stretch(clk_stretch)
  );

  // R1: power-down releases the outputs to high impedance one cycle later
  assert_pd_tristate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> !out_en);

  // R8: a dead line while locked drops lock in the next cycle
  assert_line_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && !line_active && !lock_n) |=> (lock_n && !clk_sel_rec));

  // R9: every change of clock source comes with a stretch request
  assert_stretch_on_switch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_rec != $past(clk_sel_rec)) |-> clk_stretch);
endmodule

// File: tb/link_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_lock_ctrl_tb_top;
  localparam int P_REF = 5, P_REFSS = 9, P_SET = 4, P_TO = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pd_n = 1'b0, ref_tick = 1'b0, word_found = 1'b0;
  logic line_active = 1'b1, ss_mode = 1'b0;
  logic lock_n, out_en, data_low, clk_sel_rec, clk_stretch;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  link_lock_ctrl #(
    .REF_WAIT_CYC(P_REF), .SS_REF_WAIT_CYC(P_REFSS),
    .SS_SETTLE_CYC(P_SET), .WORD_TIMEOUT_CYC(P_TO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .ref_tick(ref_tick),
    .word_found(word_found), .line_active(line_active), .ss_mode(ss_mode),
    .lock_n(lock_n), .out_en(out_en), .data_low(data_low),
    .clk_sel_rec(clk_sel_rec), .clk_stretch(clk_stretch)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1'b1; step();
      ref_tick = 1'b0; step();
    end
  endtask

  task automatic word();
    word_found = 1'b1; step();
    word_found = 1'b0;
  endtask

  // vector order: lock_n, out_en, data_low, clk_sel_rec
  task automatic chk_out(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {lock_n, out_en, data_low, clk_sel_rec};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s outputs act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chk_str(string req, logic exp);
    n_chk++;
    if (clk_stretch !== exp) begin
      n_fail++;
      $display("FAIL %s clk_stretch act=%b exp=%b", req, clk_stretch, exp);
    end
  endtask

  localparam logic [3:0] V_OFF = 4'b1010, V_UNLK = 4'b1110, V_LOCK = 4'b0101;

  task automatic t_reset();
    rst_n = 1'b0; pd_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1; step();
    chk_out("R1 reset", V_OFF);
    chk_str("R9 reset", 1'b0);
  endtask

  task automatic t_normal_acquire();
    ss_mode = 1'b0; pd_n = 1'b1; step();
    chk_out("R1 power-up", V_UNLK);
    ticks(P_REF - 1);
    word();
    chk_out("R2 word during ref wait", V_UNLK);
    ticks(1);
    chk_out("R2 hunt entered", V_UNLK);
    word();
    chk_out("R4 lock on word", V_LOCK);
    chk_str("R9 stretch on lock", 1'b1);
    step();
    chk_str("R9 stretch one cycle", 1'b0);
  endtask

  task automatic t_timeout();
    ticks(P_TO - 1);
    chk_out("R6 before timeout", V_LOCK);
    word();
    ticks(P_TO - 1);
    chk_out("R7 word restarts timeout", V_LOCK);
    ticks(1);
    chk_out("R6 timeout unlock", V_UNLK);
    // stretch pulsed in the tick cycle; sample the edge itself
  endtask

  task automatic t_timeout_stretch();
    word();
    chk_out("R6 relock after timeout", V_LOCK);
    ticks(P_TO - 1);
    ref_tick = 1'b1; step(); ref_tick = 1'b0;
    chk_out("R6 second timeout", V_UNLK);
    chk_str("R9 stretch on unlock", 1'b1);
    step();
    chk_str("R9 unlock stretch one cycle", 1'b0);
  endtask

  task automatic t_line_drop();
    word();
    chk_out("R8 relock", V_LOCK);
    line_active = 1'b0; step();
    chk_out("R8 dead line unlock", V_UNLK);
    word();
    chk_out("R8 word ignored on dead line", V_UNLK);
    line_active = 1'b1; step();
    word();
    chk_out("R8 hunt after line returns", V_LOCK);
  endtask

  task automatic t_powerdown();
    pd_n = 1'b0; step();
    chk_out("R1 power-down tristate", V_OFF);
    ticks(3);
    chk_out("R1 held in power-down", V_OFF);
  endtask

  task automatic t_ss_acquire();
    ss_mode = 1'b1; pd_n = 1'b1; step();
    chk_out("R1 power-up ss", V_UNLK);
    ticks(P_REFSS - 1);
    word();
    chk_out("R3 word during ss ref wait", V_UNLK);
    ticks(1);
    word();
    chk_out("R5 settle after word", V_UNLK);
    ticks(P_SET - 1);
    chk_out("R5 before settle end", V_UNLK);
    ticks(1);
    chk_out("R5 lock after settle", V_LOCK);
  endtask

  initial begin
    t_reset();
    t_normal_acquire();
    t_timeout();
    t_timeout_stretch();
    t_line_drop();
    t_powerdown();
    t_ss_acquire();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule